// File: doc/BRIEF.md
# Sector Buffer DMA Word Mover

This block carries a run of 16-bit words between a small local sector buffer and system memory over a request/acknowledge DMA port. A single start pulse launches a run described by a direction code, an 18-bit starting address (a 16-bit base plus a 2-bit extension), a word count held in the negative two's-complement form a disk controller register keeps, and a flag that freezes the memory address. The three directions are: buffer to memory (the disk-read case), memory to buffer (the disk-write case), and compare memory against buffer (write check).

Each word is one handshake. The engine raises its request with a read or write strobe and the address. The word is taken as finished on the falling edge of the acknowledge. At the end of the run the engine hands back the final address, split the same way it came in, so that a controller can store it in its base and extension fields. A run in write-check direction also hands back a sticky compare-error flag. The sector buffer has a separate host port, so that a testbench or a media-side engine can load it and read it back.

Top module: `dma_word_engine`

## Requirements
- R1: A run moves exactly 65536 minus `wc_in` words (a `wc_in` of 0 means 65536). The only exception is the case in R7.
- R2: The first word uses address {`ext_in`,`ba_in`}. Each later word uses the previous address plus 2, wrapping modulo 2^18.
- R3: With `inh_in` set at start, every word of the run uses the starting address, and the final address equals the starting address.
- R4: `dir` code 0 moves buffer words to memory: `dma_wr` is high, and `dma_wdata` carries buffer word i for the i-th handshake. Code 1 moves memory to buffer: `dma_rd` is high, and `dma_rdata` is stored at buffer index i. Codes 2 and 3 are write check: `dma_rd` is high and the buffer is left unchanged. `dma_rd` and `dma_wr` are high only while `dma_req` is high, and never both at once.
- R5: A word completes on the clock edge that samples `dma_ack` low after it was high. `dma_addr` holds steady while the acknowledge is high. The next request with the advanced address follows on that same edge.
- R6: In write check, `wck_err` becomes 1 when any memory word differs from the buffer word at the same index. It stays set to the end of the run, and it is cleared when the next run is accepted.
- R7: Memory-to-buffer with `inh_in` set fetches exactly one word, which is stored at buffer index 0.
- R8: On the edge that completes the last word, `dma_req` drops, {`final_ext`,`final_ba`} takes the address after the last word, and `done` goes high for exactly one cycle.
- R9: `busy` is high from the edge that accepts `start` until the edge that completes the last word. A `start` that arrives while `busy` is high has no effect, and neither do input changes made during that time.
- R10: After reset, `busy`, `done`, `dma_req`, `wck_err`, `final_ba` and `final_ext` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| dir | input | 2 | 0 buffer→memory, 1 memory→buffer, 2/3 write check |
| wc_in | input | 16 | Negative word count |
| ba_in | input | 16 | Starting address bits 15:0 |
| ext_in | input | 2 | Starting address bits 17:16 |
| inh_in | input | 1 | Freeze the memory address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| wck_err | output | 1 | Write-check mismatch seen |
| final_ba | output | 16 | Final address bits 15:0 |
| final_ext | output | 2 | Final address bits 17:16 |
| dma_req | output | 1 | DMA request |
| dma_rd | output | 1 | Memory read strobe |
| dma_wr | output | 1 | Memory write strobe |
| dma_addr | output | 18 | Memory word address |
| dma_wdata | output | 16 | Data written to memory |
| dma_ack | input | 1 | DMA acknowledge |
| dma_rdata | input | 16 | Data read from memory, valid when the acknowledge falls |
| ld_we | input | 1 | Host buffer write enable |
| ld_idx | input | 8 | Host buffer write index |
| ld_data | input | 16 | Host buffer write data |
| rb_idx | input | 8 | Host buffer read index |
| rb_data | output | 16 | Host buffer read data (combinational) |

## Verification
`busy` rises in the cycle that follows the accepting edge. A word completes two clock edges after its request, plus however many cycles the responder waits before raising the acknowledge. So for a run of n words, `done` and the final address appear exactly n×(wait+2) edges after acceptance. The bench's reference model counts those edges itself and compares `busy` and `done` one time unit after every rising edge. It checks address, strobe and write data at the moment the responder raises the acknowledge, against a queue built when the run starts. It reads the final address, `wck_err` and the buffer contents only after `done` has been seen.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam logic [1:0] DIR_TO_MEM   = 2'd0;
  localparam logic [1:0] DIR_FROM_MEM = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_ACKED = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/dma_sector_buf.sv
module dma_sector_buf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_widx,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic [IDX_W-1:0]  host_ridx,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [WORD_W-1:0] eng_wdata,
  output logic [WORD_W-1:0] eng_rdata
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  // engine write takes precedence over the host port
  always_ff @(posedge clk) begin
    if (eng_we) begin
      mem_q[eng_idx] <= eng_wdata;
    end else if (host_we) begin
      mem_q[host_widx] <= host_wdata;
    end
  end

  assign eng_rdata  = mem_q[eng_idx];
  assign host_rdata = mem_q[host_ridx];

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_hold,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr
);

  logic [AW-1:0] addr_q, addr_d;
  logic          hold_q, hold_d;

  assign next_addr = hold_q ? addr_q : addr_q + AW'(2);

  always_comb begin
    addr_d = addr_q;
    hold_d = hold_q;
    if (load) begin
      addr_d = ld_addr;
      hold_d = ld_hold;
    end else if (step) begin
      addr_d = next_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      hold_q <= 1'b0;
    end else if (load || step) begin
      addr_q <= addr_d;
      hold_q <= hold_d;
    end
  end

  assign cur_addr = addr_q;

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_eng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        dir_in,
  input  logic [WORD_W-1:0] wc_in,
  input  logic              inh_in,
  input  logic              dma_ack,
  input  logic [WORD_W-1:0] dma_rdata,
  input  logic [WORD_W-1:0] buf_word,
  output logic              busy,
  output logic              done,
  output logic              dma_req,
  output logic              dma_rd,
  output logic              dma_wr,
  output logic              load,
  output logic              step,
  output logic              last,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              wck_err
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << WORD_W;

  xfer_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       dir_q, dir_d;
  logic             err_q, err_d;
  logic             done_q;
  logic             accept, complete, one_fetch, is_check;
  logic [CNT_W-1:0] n_words;

  assign accept    = start && (state_q == ST_IDLE);
  assign complete  = (state_q == ST_ACKED) && !dma_ack;
  assign last      = complete && (cnt_q == CNT_W'(1));
  assign one_fetch = inh_in && (dir_in == DIR_FROM_MEM);
  assign n_words   = one_fetch ? CNT_W'(1) : FULL_CNT - CNT_W'(wc_in);
  assign is_check  = dir_q[1];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)   state_d = ST_REQ;
      ST_REQ:   if (dma_ack)  state_d = ST_ACKED;
      ST_ACKED: if (complete) state_d = last ? ST_IDLE : ST_REQ;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    dir_d = dir_q;
    err_d = err_q;
    if (accept) begin
      cnt_d = n_words;
      idx_d = '0;
      dir_d = dir_in;
      err_d = 1'b0;
    end else if (complete) begin
      cnt_d = cnt_q - CNT_W'(1);
      idx_d = idx_q + IDX_W'(1);
      if (is_check && (dma_rdata != buf_word)) begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      dir_q   <= DIR_TO_MEM;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last;
      if (accept || complete) begin
        cnt_q <= cnt_d;
        idx_q <= idx_d;
        dir_q <= dir_d;
        err_q <= err_d;
      end
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign dma_req = busy;
  assign dma_wr  = dma_req && (dir_q == DIR_TO_MEM);
  assign dma_rd  = dma_req && (dir_q != DIR_TO_MEM);
  assign load    = accept;
  assign step    = complete;
  assign buf_we  = complete && (dir_q == DIR_FROM_MEM);
  assign buf_idx = idx_q;
  assign wck_err = err_q;

endmodule

// File: rtl/dma_word_engine.sv
module dma_word_engine #(
  parameter int WORD_W    = 16,
  parameter int EXT_W     = 2,
  parameter int BUF_DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [1:0]                   dir,
  input  logic [WORD_W-1:0]            wc_in,
  input  logic [WORD_W-1:0]            ba_in,
  input  logic [EXT_W-1:0]             ext_in,
  input  logic                         inh_in,
  output logic                         busy,
  output logic                         done,
  output logic                         wck_err,
  output logic [WORD_W-1:0]            final_ba,
  output logic [EXT_W-1:0]             final_ext,
  output logic                         dma_req,
  output logic                         dma_rd,
  output logic                         dma_wr,
  output logic [WORD_W+EXT_W-1:0]      dma_addr,
  output logic [WORD_W-1:0]            dma_wdata,
  input  logic                         dma_ack,
  input  logic [WORD_W-1:0]            dma_rdata,
  input  logic                         ld_we,
  input  logic [$clog2(BUF_DEPTH)-1:0] ld_idx,
  input  logic [WORD_W-1:0]            ld_data,
  input  logic [$clog2(BUF_DEPTH)-1:0] rb_idx,
  output logic [WORD_W-1:0]            rb_data
);

  localparam int AW    = WORD_W + EXT_W;
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = WORD_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              load, step, last, buf_we;
  logic [IDX_W-1:0]  buf_idx;
  logic [WORD_W-1:0] buf_word;
  logic [AW-1:0]     cur_addr, next_addr;
  logic [AW-1:0]     final_q, final_d;

  dma_xfer_fsm #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .dir_in    (dir),
    .wc_in     (wc_in),
    .inh_in    (inh_in),
    .dma_ack   (dma_ack),
    .dma_rdata (dma_rdata),
    .buf_word  (buf_word),
    .busy      (busy),
    .done      (done),
    .dma_req   (dma_req),
    .dma_rd    (dma_rd),
    .dma_wr    (dma_wr),
    .load      (load),
    .step      (step),
    .last      (last),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .wck_err   (wck_err)
  );

  dma_addr_unit #(
    .AW (AW)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (load),
    .ld_addr   ({ext_in, ba_in}),
    .ld_hold   (inh_in),
    .step      (step),
    .cur_addr  (cur_addr),
    .next_addr (next_addr)
  );

  dma_sector_buf #(
    .WORD_W (WORD_W),
    .DEPTH  (BUF_DEPTH),
    .IDX_W  (IDX_W)
  ) u_buf (
    .clk        (clk),
    .host_we    (ld_we),
    .host_widx  (ld_idx),
    .host_wdata (ld_data),
    .host_ridx  (rb_idx),
    .host_rdata (rb_data),
    .eng_we     (buf_we),
    .eng_idx    (buf_idx),
    .eng_wdata  (dma_rdata),
    .eng_rdata  (buf_word)
  );

  // final address capture on the last completed word
  always_comb begin
    final_d = final_q;
    if (last) final_d = next_addr;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  final_q <= '0;
    else if (last)   final_q <= final_d;
  end

  assign final_ba  = final_q[WORD_W-1:0];
  assign final_ext = final_q[AW-1:WORD_W];
  assign dma_addr  = cur_addr;
  assign dma_wdata = buf_word;

endmodule

// File: rtl/dma_word_engine_chk.sv
module dma_word_engine_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          dma_req,
  input logic          dma_rd,
  input logic          dma_wr,
  input logic          dma_ack,
  input logic [AW-1:0] dma_addr
);

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $onehot({dma_rd, dma_wr}));

  assert_strobe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |-> (!dma_rd && !dma_wr));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> $stable(dma_addr));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !dma_req));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> busy);

endmodule

bind dma_word_engine dma_word_engine_chk #(.AW(WORD_W + EXT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .dma_req  (dma_req),
  .dma_rd   (dma_rd),
  .dma_wr   (dma_wr),
  .dma_ack  (dma_ack),
  .dma_addr (dma_addr)
);

// File: tb/dma_word_engine_bench.sv
`timescale 1ns/1ps
module dma_word_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  dir;
  logic [15:0] wc_in, ba_in;
  logic [1:0]  ext_in;
  logic        inh_in;
  logic        busy, done, wck_err;
  logic [15:0] final_ba;
  logic [1:0]  final_ext;
  logic        dma_req, dma_rd, dma_wr;
  logic [17:0] dma_addr;
  logic [15:0] dma_wdata;
  logic        dma_ack;
  logic [15:0] dma_rdata;
  logic        ld_we;
  logic [7:0]  ld_idx, rb_idx;
  logic [15:0] ld_data, rb_data;

  always #2 clk = ~clk;

  dma_word_engine u_dma_word_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .wc_in(wc_in),
    .ba_in(ba_in), .ext_in(ext_in), .inh_in(inh_in), .busy(busy), .done(done),
    .wck_err(wck_err), .final_ba(final_ba), .final_ext(final_ext),
    .dma_req(dma_req), .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data), .rb_idx(rb_idx),
    .rb_data(rb_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lat    = 0;
  int m_words = 0;
  int m_rem  = 0;
  logic m_exp_done = 1'b0;
  logic model_on   = 1'b0;

  bit [15:0] bmem [int];
  bit [15:0] bbuf [256];
  int        exp_addr[$];
  bit [15:0] exp_wd[$];
  bit        exp_is_wr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [15:0] mem_val(input int a);
    if (bmem.exists(a)) return bmem[a];
    return 16'(a * 7 + 16'h1234);
  endfunction

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // memory responder: raises ack after lat waiting cycles, drops it next cycle
  initial begin : responder
    int wcnt;
    wcnt = 0;
    dma_ack = 1'b0;
    dma_rdata = '0;
    forever begin
      @(negedge clk);
      if (dma_ack) begin
        dma_ack = 1'b0;
      end else if (dma_req && rst_n) begin
        if (wcnt == lat) begin
          wcnt = 0;
          dma_ack = 1'b1;
          if (exp_addr.size() == 0) begin
            chk(1'b0, "R1 extra handshake", int'(dma_addr), 0);
          end else begin
            int ea;
            bit [15:0] ew;
            ea = exp_addr.pop_front();
            ew = exp_wd.pop_front();
            chk(int'(dma_addr) == ea, "R2/R3 address", int'(dma_addr), ea);
            chk(dma_wr == exp_is_wr && dma_rd == !exp_is_wr, "R4 strobe",
                int'({dma_rd, dma_wr}), int'({!exp_is_wr, exp_is_wr}));
            if (dma_wr) begin
              chk(dma_wdata == ew, "R4 write data", int'(dma_wdata), int'(ew));
              bmem[int'(dma_addr)] = dma_wdata;
            end else begin
              dma_rdata = mem_val(int'(dma_addr));
            end
          end
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  // cycle reference model for busy/done
  initial begin : model
    forever begin
      @(posedge clk);
      #1;
      if (model_on) begin
        m_exp_done = 1'b0;
        if (m_rem > 0) begin
          m_rem--;
          if (m_rem == 0) m_exp_done = 1'b1;
        end else if (start) begin
          m_rem = m_words * (lat + 2);
        end
        chk(busy == (m_rem > 0), "R9 busy", int'(busy), int'(m_rem > 0));
        chk(done == m_exp_done, "R8 done", int'(done), int'(m_exp_done));
      end
    end
  end

  task automatic load_buf(input int seed);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_we = 1'b1;
      ld_idx = 8'(i);
      ld_data = 16'(i * 16'h0101 + seed);
      bbuf[i] = 16'(i * 16'h0101 + seed);
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run_xfer(input logic [1:0] d, input logic [15:0] wc,
                          input logic [1:0] ext, input logic [15:0] ba,
                          input logic inh, input int l, input bit poke,
                          input bit exp_err);
    int n, a, guard;
    bit seen;
    n = (d == 2'd1 && inh) ? 1 : 65536 - int'(wc);
    a = int'({ext, ba});
    exp_is_wr = (d == 2'd0);
    for (int i = 0; i < n; i++) begin
      exp_addr.push_back(a);
      exp_wd.push_back(bbuf[i % 256]);
      if (d == 2'd1) bbuf[i % 256] = mem_val(a);
      if (!inh) a = (a + 2) & 32'h3FFFF;
    end
    @(negedge clk);
    lat = l; m_words = n;
    dir = d; wc_in = wc; ext_in = ext; ba_in = ba; inh_in = inh;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      dir = ~d; wc_in = 16'hFFF0; ba_in = 16'h7777; ext_in = ~ext; inh_in = ~inh;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    guard = 0;
    while (!seen && guard < 2000) begin
      @(posedge clk);
      #1;
      seen = done;
      guard++;
    end
    chk(seen, "R8 done seen", int'(seen), 1);
    chk(exp_addr.size() == 0, "R1 word count", exp_addr.size(), 0);
    chk({final_ext, final_ba} == 18'(a), "R8 final address",
        int'({final_ext, final_ba}), a);
    chk(dma_req == 1'b0, "R8 request dropped", int'(dma_req), 0);
    chk(wck_err == exp_err, "R6 check error", int'(wck_err), int'(exp_err));
    exp_addr.delete();
    exp_wd.delete();
    @(negedge clk);
  endtask

  task automatic check_buf(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rb_idx = 8'(i);
      #1;
      chk(rb_data == bbuf[i], req, int'(rb_data), int'(bbuf[i]));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0; dir = 2'd0; wc_in = '0; ba_in = '0; ext_in = '0; inh_in = 1'b0;
    ld_we = 1'b0; ld_idx = '0; ld_data = '0; rb_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0 && dma_req == 0, "R10 control idle",
        int'({busy, done, dma_req}), 0);
    chk(wck_err == 0 && final_ba == 0 && final_ext == 0, "R10 results zero",
        int'({wck_err, final_ext, final_ba}), 0);
    load_buf(16'h0300);
    model_on = 1'b1;

    // R1 R2: to memory, carry out of bit 15 into extension
    run_xfer(2'd0, 16'hFFFC, 2'd1, 16'hFFFC, 1'b0, 0, 1'b0, 1'b0);
    // R3: frozen address, to memory, with wait states
    run_xfer(2'd0, 16'hFFFD, 2'd0, 16'h0100, 1'b1, 2, 1'b0, 1'b0);
    // R2: wrap at 18 bits
    run_xfer(2'd0, 16'hFFFE, 2'd3, 16'hFFFE, 1'b0, 1, 1'b0, 1'b0);
    // R4 memory to buffer, then read back
    run_xfer(2'd1, 16'hFFFB, 2'd2, 16'h0400, 1'b0, 0, 1'b0, 1'b0);
    check_buf(5, "R4 buffer stored");
    // R7 single fetch with frozen address
    run_xfer(2'd1, 16'hFFF8, 2'd0, 16'h0800, 1'b1, 1, 1'b0, 1'b0);
    check_buf(2, "R7 buffer index 0 only");
    // R6 write check: store buffer then compare equal
    run_xfer(2'd0, 16'hFFFA, 2'd0, 16'h2000, 1'b0, 0, 1'b0, 1'b0);
    run_xfer(2'd2, 16'hFFFA, 2'd0, 16'h2000, 1'b0, 0, 1'b0, 1'b0);
    check_buf(6, "R4 check leaves buffer");
    // R6 mismatch
    bmem[32'h2004] = ~bmem[32'h2004];
    run_xfer(2'd3, 16'hFFFA, 2'd0, 16'h2000, 1'b0, 1, 1'b0, 1'b1);
    // R6 cleared on next accepted run
    run_xfer(2'd2, 16'hFFFF, 2'd0, 16'h2000, 1'b0, 0, 1'b0, 1'b0);
    // R9 start and input changes while busy ignored
    run_xfer(2'd0, 16'hFFF9, 2'd1, 16'h3000, 1'b0, 1, 1'b1, 1'b0);

    model_on = 1'b0;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule